// File: doc/BRIEF.md
# Frame-Synchronous PCM Tone Inserter

This block sits on the outgoing path of a 32-slot serial TDM PCM stream, ahead of the serialiser. Each clock it takes one 8-bit sample together with the timeslot index that sample belongs to. It returns either that sample unchanged or a fixed companded square-wave tone code, one clock later. A channel carries the tone only when two things hold: its bit in the conference-enable mask is set, and tone insertion is active for the current frame.

Tone insertion is decided once per frame. At each clock edge where the frame pulse is high, a small state machine captures the tone request and the level of the external square wave. The chosen state then governs every sample registered after that edge, up to and including the next frame-pulse edge. The sample captured on the pulse edge itself still uses the old state. As a result every enabled channel carries the same tone value for a whole frame, and toggling the request or the square wave mid-frame has no visible effect until the next pulse.

The states are:
- `ST_IDLE`: after reset, nothing latched yet; samples pass through.
- `ST_PASS`: tone not requested; samples pass through.
- `ST_TONE_POS`: tone on, positive half-cycle.
- `ST_TONE_NEG`: tone on, negative half-cycle.

There is one transition per frame-pulse edge, and it can start from any state:
- *to_pass*: the request is low.
- *to_pos*: the request is high and the square wave is high.
- *to_neg*: the request is high and the square wave is low.

With no frame pulse the state holds (*hold*). Reset forces `ST_IDLE`.

Top module: `tone_inserter`

## Requirements
- R1: While reset is low, `pcm_out` is 8'h00. After reset is released, samples pass through unchanged until a frame-pulse edge latches a tone request, even if `tone_req` is high before that edge.
- R2: When the latched frame state is not a tone state, `pcm_out` equals the `pcm_in` presented one clock earlier.
- R3: When the latched state is a tone state and `ch_enable[slot_idx]` is 1, `pcm_out` one clock later is the tone code. The positive code is used when `tone_sq` was 1 at the latching edge, and the negative code when it was 0.
- R4: A sample whose slot has `ch_enable[slot_idx]` = 0 passes unchanged one clock later, whatever the tone state.
- R5: `tone_req` and `tone_sq` are sampled only at edges where `frame_pulse` is 1. Changes between pulses do not alter the output until the sample after the next pulse edge.
- R6: With `law_mu` = 0 (A-law), the positive tone code is 8'h9C and the negative tone code is 8'h1C. These are one tenth of full scale, with even bits inverted.
- R7: With `law_mu` = 1 (µ-law), the positive tone code is 8'h35 and the negative tone code is 8'hB5. These are one tenth of full scale, with all bits inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse | input | 1 | High for one clock at each frame boundary |
| tone_req | input | 1 | Tone insertion request, sampled at frame pulse |
| tone_sq | input | 1 | External tone square wave, sampled at frame pulse |
| law_mu | input | 1 | Companding law: 0 A-law, 1 µ-law |
| ch_enable | input | 32 | Per-timeslot conference enable mask |
| slot_idx | input | 5 | Timeslot index of `pcm_in` |
| pcm_in | input | 8 | Normal PCM sample |
| pcm_out | output | 8 | Selected sample, registered |

## Verification
The frame state is never visible at the ports, so a corrupted state can only show up as a wrong sample on an enabled slot. Examples are a tone code where data was expected, the wrong polarity, or a tone that persists. Such an error appears one clock after the first enabled-slot sample that follows the bad state. A mis-timed latch shows up as a change within the same frame in which `tone_req` or `tone_sq` was toggled. Samples on disabled slots must stay transparent regardless, which separates mask faults from state faults.

// File: rtl/tone_ins_pkg.sv
package tone_ins_pkg;

    localparam int CODE_W   = 8;
    localparam int NUM_LAWS = 2;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PASS     = 2'd1,
        ST_TONE_POS = 2'd2,
        ST_TONE_NEG = 2'd3
    } tone_state_e;

    typedef enum logic {
        LAW_A  = 1'b0,
        LAW_MU = 1'b1
    } law_e;

    // Segment/mantissa magnitude for a level of 0.1 full scale, before line coding.
    localparam logic [6:0] A_MAG  = 7'h49;  // segment 4, step 9
    localparam logic [6:0] MU_MAG = 7'h4A;  // segment 4, step 10

    function automatic logic [CODE_W-1:0] tone_code(input law_e law, input logic positive);
        logic [CODE_W-1:0] raw;
        if (law == LAW_A) begin
            raw = {positive, A_MAG};
            return raw ^ 8'h55;
        end
        raw = {positive, MU_MAG};
        return ~raw;
    endfunction

endpackage

// File: rtl/tone_frame_fsm.sv
module tone_frame_fsm
    import tone_ins_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_pulse,
    input  logic        tone_req,
    input  logic        tone_sq,
    output tone_state_e state_q,
    output logic        tone_on,
    output logic        tone_pos
);

    tone_state_e state_d;

    // next-state selection: one decision per frame pulse
    always_comb begin
        state_d = state_q;
        if (frame_pulse) begin
            if (!tone_req)    state_d = ST_PASS;
            else if (tone_sq) state_d = ST_TONE_POS;
            else              state_d = ST_TONE_NEG;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        tone_on  = 1'b0;
        tone_pos = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_PASS:     ;
            ST_TONE_POS: begin tone_on = 1'b1; tone_pos = 1'b1; end
            ST_TONE_NEG: tone_on = 1'b1;
        endcase
    end

endmodule

// File: rtl/tone_code_table.sv
module tone_code_table
    import tone_ins_pkg::*;
(
    input  logic              law_mu,
    input  logic              tone_pos,
    output logic [CODE_W-1:0] code
);

    logic [CODE_W-1:0] pos_codes [NUM_LAWS];
    logic [CODE_W-1:0] neg_codes [NUM_LAWS];

    for (genvar g = 0; g < NUM_LAWS; g++) begin : g_law
        assign pos_codes[g] = tone_code(law_e'(g), 1'b1);
        assign neg_codes[g] = tone_code(law_e'(g), 1'b0);
    end

    assign code = tone_pos ? pos_codes[law_mu] : neg_codes[law_mu];

endmodule

// File: rtl/slot_sel_mux.sv
module slot_sel_mux
    import tone_ins_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tone_on,
    input  logic [CODE_W-1:0]    tone_val,
    input  logic [NUM_SLOTS-1:0] ch_enable,
    input  logic [SLOT_W-1:0]    slot_idx,
    input  logic [CODE_W-1:0]    pcm_in,
    output logic [CODE_W-1:0]    pcm_out
);

    logic              slot_hit;
    logic [CODE_W-1:0] sel_d;

    assign slot_hit = ch_enable[slot_idx];
    assign sel_d    = (tone_on && slot_hit) ? tone_val : pcm_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcm_out <= '0;
        else        pcm_out <= sel_d;
    end

endmodule

// File: rtl/tone_inserter.sv
module tone_inserter
    import tone_ins_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_pulse,
    input  logic                 tone_req,
    input  logic                 tone_sq,
    input  logic                 law_mu,
    input  logic [NUM_SLOTS-1:0] ch_enable,
    input  logic [SLOT_W-1:0]    slot_idx,
    input  logic [7:0]           pcm_in,
    output logic [7:0]           pcm_out
);

    tone_state_e       fsm_state;
    logic              tone_on;
    logic              tone_pos;
    logic [CODE_W-1:0] tone_val;

    tone_frame_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_pulse (frame_pulse),
        .tone_req    (tone_req),
        .tone_sq     (tone_sq),
        .state_q     (fsm_state),
        .tone_on     (tone_on),
        .tone_pos    (tone_pos)
    );

    tone_code_table u_codes (
        .law_mu   (law_mu),
        .tone_pos (tone_pos),
        .code     (tone_val)
    );

    slot_sel_mux #(.NUM_SLOTS(NUM_SLOTS)) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .tone_on   (tone_on),
        .tone_val  (tone_val),
        .ch_enable (ch_enable),
        .slot_idx  (slot_idx),
        .pcm_in    (pcm_in),
        .pcm_out   (pcm_out)
    );

endmodule

// File: rtl/tone_inserter_chk.sv
module tone_inserter_chk
    import tone_ins_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_pulse,
    input  logic                 law_mu,
    input  logic [NUM_SLOTS-1:0] ch_enable,
    input  logic [SLOT_W-1:0]    slot_idx,
    input  logic [7:0]           pcm_in,
    input  logic [7:0]           pcm_out,
    input  tone_state_e          state
);

    logic hit;
    logic tone_st;
    assign hit     = ch_enable[slot_idx];
    assign tone_st = (state == ST_TONE_POS) || (state == ST_TONE_NEG);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pcm_out == 8'h00));

    // R2
    pass_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tone_st |=> (pcm_out == $past(pcm_in)));

    // R4
    masked_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> (pcm_out == $past(pcm_in)));

    // R3
    tone_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tone_st && hit) |=> (pcm_out == 8'h9C || pcm_out == 8'h1C ||
                              pcm_out == 8'h35 || pcm_out == 8'hB5));

    // R5
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_pulse |=> $stable(state));

    // R6
    alaw_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TONE_POS && hit && law_mu == LAW_A) |=> (pcm_out == 8'h9C));

    // R7
    mulaw_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TONE_NEG && hit && law_mu == LAW_MU) |=> (pcm_out == 8'hB5));

endmodule

bind tone_inserter tone_inserter_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_pulse (frame_pulse),
    .law_mu      (law_mu),
    .ch_enable   (ch_enable),
    .slot_idx    (slot_idx),
    .pcm_in      (pcm_in),
    .pcm_out     (pcm_out),
    .state       (fsm_state)
);

// File: tb/tb_tone_inserter.sv
module tb_tone_inserter;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 15;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_pulse, tone_req, tone_sq, law_mu;
    logic [31:0] ch_enable;
    logic [4:0]  slot_idx;
    logic [7:0]  pcm_in;
    logic [7:0]  pcm_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tone_inserter dut (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .tone_req(tone_req),
        .tone_sq(tone_sq), .law_mu(law_mu), .ch_enable(ch_enable),
        .slot_idx(slot_idx), .pcm_in(pcm_in), .pcm_out(pcm_out)
    );

    // fields: {req[3:0], pulse, req_in, sq, law, slot[4:0], pcm[7:0], expected[7:0]}
    // enabled slots: 0,1,4..7,12..15
    localparam logic [28:0] VEC [NVEC] = '{
        {4'd1, 1'b0,1'b1,1'b1,1'b0, 5'd0,  8'h11, 8'h11}, // R1 idle passes despite request
        {4'd5, 1'b1,1'b1,1'b1,1'b0, 5'd0,  8'h22, 8'h22}, // R5 pulse edge uses old state
        {4'd5, 1'b0,1'b0,1'b0,1'b0, 5'd0,  8'h33, 8'h9C}, // R5 mid-frame drop ignored, R6
        {4'd4, 1'b0,1'b0,1'b0,1'b0, 5'd2,  8'h44, 8'h44}, // R4 disabled slot
        {4'd7, 1'b0,1'b0,1'b0,1'b1, 5'd1,  8'h55, 8'h35}, // R7 mu-law positive
        {4'd5, 1'b1,1'b1,1'b0,1'b0, 5'd5,  8'h66, 8'h9C}, // R5 still positive on pulse
        {4'd6, 1'b0,1'b1,1'b1,1'b0, 5'd5,  8'h77, 8'h1C}, // R6 A-law negative, R5 sq toggle ignored
        {4'd7, 1'b0,1'b1,1'b1,1'b1, 5'd12, 8'h88, 8'hB5}, // R7 mu-law negative
        {4'd4, 1'b0,1'b1,1'b1,1'b1, 5'd31, 8'h99, 8'h99}, // R4 last slot disabled
        {4'd3, 1'b1,1'b0,1'b1,1'b0, 5'd13, 8'hAA, 8'h1C}, // R3 negative until pulse
        {4'd2, 1'b0,1'b1,1'b1,1'b0, 5'd13, 8'hBB, 8'hBB}, // R2 tone off passes
        {4'd2, 1'b0,1'b1,1'b1,1'b1, 5'd0,  8'hCC, 8'hCC}, // R2 tone off, mu-law
        {4'd2, 1'b1,1'b1,1'b1,1'b1, 5'd0,  8'hDD, 8'hDD}, // R2 pulse edge still off
        {4'd3, 1'b0,1'b1,1'b1,1'b1, 5'd15, 8'hEE, 8'h35}, // R3 positive tone
        {4'd4, 1'b0,1'b1,1'b1,1'b1, 5'd16, 8'h01, 8'h01}  // R4 slot 16 disabled
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: pcm_out=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic p, input logic r, input logic s, input logic l,
                         input logic [4:0] sl, input logic [7:0] d);
        frame_pulse = p; tone_req = r; tone_sq = s; law_mu = l;
        slot_idx = sl; pcm_in = d;
    endtask

    initial begin
        rst_n = 1'b0;
        ch_enable = 32'h0000_F0F3;
        drive(1'b1, 1'b1, 1'b1, 1'b0, 5'd0, 8'h7E);
        repeat (3) @(negedge clk);
        check("R1", pcm_out, 8'h00);                  // R1 held clear in reset
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            logic [28:0] v;
            v = VEC[i];
            drive(v[24], v[23], v[22], v[21], v[20:16], v[15:8]);
            @(negedge clk);
            check($sformatf("R%0d vec%0d", v[28:25], i), pcm_out, v[7:0]);
        end

        // R1: reset mid-tone returns to pass-through
        rst_n = 1'b0;
        drive(1'b0, 1'b1, 1'b1, 1'b0, 5'd0, 8'h5A);
        @(negedge clk);
        check("R1 reset mid-tone", pcm_out, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", pcm_out, 8'h5A);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 5'd1, 8'h12);
        @(negedge clk);
        check("R5 pulse uses idle state", pcm_out, 8'h12);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 5'd1, 8'h13);
        @(negedge clk);
        check("R3 tone after pulse", pcm_out, 8'h9C);
        // R4: all slots disabled while tone active
        ch_enable = 32'h0;
        drive(1'b0, 1'b1, 1'b1, 1'b0, 5'd1, 8'h14);
        @(negedge clk);
        check("R4 mask cleared", pcm_out, 8'h14);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule